// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block decides whether software may load and run the routine that programs or erases an on-chip flash array, and it stops a running program/erase operation when it sees something that is not allowed. Software sets up permission through a small register port. It writes a download-enable bit and a RAM-emulation select bit into a control register, and it writes an 8-bit key into a key register. Download is permitted only when the download-enable bit is set, the key matches the fixed code, and emulation is off. Program/erase needs the key and emulation off.

While the flash sequencer reports that an operation is running, the block watches four event lines. These are an interrupt request (NMI included), any read of the array (data, vector or instruction fetch), entry to sleep or software standby, and bus ownership by a master other than the CPU. Any of them raises the abort output in the same cycle and latches a sticky error flag. From the next clock edge, that flag withdraws all permission until reset.

Top module: `flash_pe_guard`

## Requirements
- R1: After a synchronous reset, `dl_allow`, `pe_enable`, `pe_abort` and `err_flag` are 0, and both registers read 8'h00.
- R2: `pe_enable` is 1 only while the key register (address 1) holds 8'hA5 and no other blocking condition holds. Any other key value gives `pe_enable` = 0 and `dl_allow` = 0.
- R3: `dl_allow` additionally requires the download-enable bit, bit 0 of the control register (address 0). With that bit at 0, `dl_allow` is 0, while `pe_enable` is unaffected.
- R4: When the RAM-emulation bit, bit 1 of the control register, is 1, both `dl_allow` and `pe_enable` are 0.
- R5: An interrupt request (`ev_irq`) while `pe_busy` is 1 raises `pe_abort` in the same cycle and sets `err_flag` at the next clock edge.
- R6: A flash array read (`ev_array_rd`) while `pe_busy` is 1 raises `pe_abort` in the same cycle and sets `err_flag` at the next edge.
- R7: A sleep or standby entry (`ev_sleep`) while `pe_busy` is 1 raises `pe_abort` in the same cycle and sets `err_flag` at the next edge.
- R8: Bus ownership by another master (`ev_alt_master`) while `pe_busy` is 1 raises `pe_abort` in the same cycle and sets `err_flag` at the next edge.
- R9: Once set, `err_flag` stays 1 until reset. From the edge that sets it, `pe_enable` and `dl_allow` are 0 whatever the register contents.
- R10: Bit 7 of the control register reads back `err_flag`. Software writes to that bit have no effect on the flag.
- R11: While `pe_busy` is 0, the event inputs have no effect: `pe_abort` stays 0 and `err_flag` is unchanged.
- R12: The registers read back what was written: address 0 gives {err_flag, 5'b0, emulation bit, download-enable bit}, address 1 gives the key, and addresses 2 and 3 read 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from the address) |
| pe_busy | input | 1 | Sequencer reports a program/erase operation in progress |
| ev_irq | input | 1 | Interrupt request, NMI included |
| ev_array_rd | input | 1 | Any read of the flash array |
| ev_sleep | input | 1 | Sleep or software-standby entry |
| ev_alt_master | input | 1 | Non-CPU master owns the bus |
| dl_allow | output | 1 | Download of the program/erase routine permitted |
| pe_enable | output | 1 | Program/erase permitted |
| pe_abort | output | 1 | Abort request to the sequencer |
| err_flag | output | 1 | Sticky error-protection flag |

## Verification
A wrong error latch shows at the ports one edge after the offending cycle. `err_flag` and `pe_enable` disagree with the event history, or the control register's top bit reads back wrongly. A fault in the event gating shows in the same cycle as `pe_abort`, because that output is combinational. A fault in the key compare or the control bits shows at once on `dl_allow` and `pe_enable` after the write edge. Each event class is driven alone, both idle and busy, so that a dropped or misrouted line can be seen.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    localparam int NUM_EV = 4;

    // register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_KEY  = 2'd1;

    // control register bit positions
    localparam int CTRL_DLEN_BIT = 0;
    localparam int CTRL_EMUL_BIT = 1;
    localparam int CTRL_ERR_BIT  = 7;

    localparam logic [7:0] DEFAULT_KEY = 8'hA5;

    typedef struct packed {
        logic alt_master;
        logic low_power;
        logic array_rd;
        logic irq;
    } pe_events_t;

    function automatic logic key_matches(input logic [7:0] k, input logic [7:0] ref_key);
        return k == ref_key;
    endfunction

endpackage

// File: rtl/fpg_regs.sv
module fpg_regs
    import fpg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              err_i,
    output logic              dl_en_o,
    output logic              emul_o,
    output logic [DATA_W-1:0] key_o,
    output logic [DATA_W-1:0] rdata
);

    logic              dl_en_q;
    logic              emul_q;
    logic [DATA_W-1:0] key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dl_en_q <= 1'b0;
            emul_q  <= 1'b0;
            key_q   <= '0;
        end else if (wr) begin
            if (addr == ADDR_W'(ADDR_CTRL)) begin
                dl_en_q <= wdata[CTRL_DLEN_BIT];
                emul_q  <= wdata[CTRL_EMUL_BIT];
            end else if (addr == ADDR_W'(ADDR_KEY)) begin
                key_q <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rdata[CTRL_DLEN_BIT] = dl_en_q;
            rdata[CTRL_EMUL_BIT] = emul_q;
            rdata[CTRL_ERR_BIT]  = err_i;
        end else if (addr == ADDR_W'(ADDR_KEY)) begin
            rdata = key_q;
        end
    end

    assign dl_en_o = dl_en_q;
    assign emul_o  = emul_q;
    assign key_o   = key_q;

endmodule

// File: rtl/fpg_event_mon.sv
module fpg_event_mon
    import fpg_pkg::*;
#(
    parameter int N_EV = NUM_EV
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            busy,
    input  logic [N_EV-1:0] ev,
    output logic            abort_o,
    output logic            err_o
);

    logic [N_EV-1:0] hit;
    logic            err_q;

    for (genvar i = 0; i < N_EV; i++) begin : g_gate
        assign hit[i] = busy & ev[i];
    end

    assign abort_o = |hit;

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (abort_o) err_q <= 1'b1;
    end

    assign err_o = err_q;

endmodule

// File: rtl/fpg_perm.sv
module fpg_perm
    import fpg_pkg::*;
#(
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] KEY_VALUE = DEFAULT_KEY
) (
    input  logic [DATA_W-1:0] key,
    input  logic              dl_en,
    input  logic              emul,
    input  logic              err,
    output logic              dl_allow_o,
    output logic              pe_enable_o
);

    logic key_ok;
    assign key_ok      = (key == KEY_VALUE);
    assign pe_enable_o = key_ok & ~emul & ~err;
    assign dl_allow_o  = pe_enable_o & dl_en;

endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard
    import fpg_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 2,
    parameter logic [DATA_W-1:0] KEY_VALUE = DEFAULT_KEY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              pe_busy,
    input  logic              ev_irq,
    input  logic              ev_array_rd,
    input  logic              ev_sleep,
    input  logic              ev_alt_master,
    output logic              dl_allow,
    output logic              pe_enable,
    output logic              pe_abort,
    output logic              err_flag
);

    pe_events_t        evs;
    logic              dl_en, emul, err;
    logic [DATA_W-1:0] key;

    assign evs.irq        = ev_irq;
    assign evs.array_rd   = ev_array_rd;
    assign evs.low_power  = ev_sleep;
    assign evs.alt_master = ev_alt_master;

    fpg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .err_i(err), .dl_en_o(dl_en), .emul_o(emul), .key_o(key), .rdata(reg_rdata)
    );

    fpg_event_mon #(.N_EV(NUM_EV)) u_mon (
        .clk(clk), .rst(rst), .busy(pe_busy), .ev(evs),
        .abort_o(pe_abort), .err_o(err)
    );

    fpg_perm #(.DATA_W(DATA_W), .KEY_VALUE(KEY_VALUE)) u_perm (
        .key(key), .dl_en(dl_en), .emul(emul), .err(err),
        .dl_allow_o(dl_allow), .pe_enable_o(pe_enable)
    );

    assign err_flag = err;

endmodule

// File: rtl/flash_pe_guard_chk.sv
module flash_pe_guard_chk (
    input logic clk,
    input logic rst,
    input logic pe_busy,
    input logic ev_irq,
    input logic ev_array_rd,
    input logic ev_sleep,
    input logic ev_alt_master,
    input logic dl_allow,
    input logic pe_enable,
    input logic pe_abort,
    input logic err_flag
);

    // R11
    idle_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        !pe_busy |-> !pe_abort);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R9
    abort_drops_enable_chk: assert property (@(posedge clk) disable iff (rst)
        pe_abort |=> (err_flag && !pe_enable && !dl_allow));

    // R5
    irq_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (pe_busy && ev_irq) |-> pe_abort);

    // R6
    rd_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (pe_busy && ev_array_rd) |-> pe_abort);

    // R7
    sleep_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (pe_busy && ev_sleep) |-> pe_abort);

    // R8
    master_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (pe_busy && ev_alt_master) |-> pe_abort);

    // R3
    dl_needs_pe_chk: assert property (@(posedge clk) disable iff (rst)
        dl_allow |-> pe_enable);

    // R10
    err_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(pe_abort));

endmodule

bind flash_pe_guard flash_pe_guard_chk u_chk (
    .clk(clk), .rst(rst), .pe_busy(pe_busy), .ev_irq(ev_irq),
    .ev_array_rd(ev_array_rd), .ev_sleep(ev_sleep), .ev_alt_master(ev_alt_master),
    .dl_allow(dl_allow), .pe_enable(pe_enable), .pe_abort(pe_abort), .err_flag(err_flag)
);

// File: tb/flash_pe_guard_test.sv
module flash_pe_guard_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       pe_busy, ev_irq, ev_array_rd, ev_sleep, ev_alt_master;
    logic       dl_allow, pe_enable, pe_abort, err_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pe_guard uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pe_busy(pe_busy),
        .ev_irq(ev_irq), .ev_array_rd(ev_array_rd), .ev_sleep(ev_sleep),
        .ev_alt_master(ev_alt_master), .dl_allow(dl_allow), .pe_enable(pe_enable),
        .pe_abort(pe_abort), .err_flag(err_flag)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        pe_busy = 1'b0; ev_irq = 1'b0; ev_array_rd = 1'b0; ev_sleep = 1'b0; ev_alt_master = 1'b0;
        wait_edge();
        wait_edge();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        wait_edge();
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic arm();
        write_reg(2'd1, 8'hA5);
        write_reg(2'd0, 8'h01);
    endtask

    task automatic test_reset();
        logic [7:0] d;
        do_reset();
        #1;
        check("R1", "dl_allow", {7'b0, dl_allow}, 8'h00);
        check("R1", "pe_enable", {7'b0, pe_enable}, 8'h00);
        check("R1", "pe_abort", {7'b0, pe_abort}, 8'h00);
        check("R1", "err_flag", {7'b0, err_flag}, 8'h00);
        read_reg(2'd0, d); check("R1", "ctrl", d, 8'h00);
        read_reg(2'd1, d); check("R1", "key", d, 8'h00);
    endtask

    task automatic test_key();
        do_reset();
        write_reg(2'd0, 8'h01);
        write_reg(2'd1, 8'hA4);
        check("R2", "pe_enable wrong key", {7'b0, pe_enable}, 8'h00);
        check("R2", "dl_allow wrong key", {7'b0, dl_allow}, 8'h00);
        write_reg(2'd1, 8'h5A);
        check("R2", "pe_enable swapped key", {7'b0, pe_enable}, 8'h00);
        write_reg(2'd1, 8'hA5);
        check("R2", "pe_enable good key", {7'b0, pe_enable}, 8'h01);
        check("R2", "dl_allow good key", {7'b0, dl_allow}, 8'h01);
        write_reg(2'd1, 8'h00);
        check("R2", "pe_enable key cleared", {7'b0, pe_enable}, 8'h00);
    endtask

    task automatic test_dl_bit();
        do_reset();
        write_reg(2'd1, 8'hA5);
        check("R3", "dl_allow dl bit 0", {7'b0, dl_allow}, 8'h00);
        check("R3", "pe_enable dl bit 0", {7'b0, pe_enable}, 8'h01);
        write_reg(2'd0, 8'h01);
        check("R3", "dl_allow dl bit 1", {7'b0, dl_allow}, 8'h01);
    endtask

    task automatic test_emul();
        do_reset();
        write_reg(2'd1, 8'hA5);
        write_reg(2'd0, 8'h03);
        check("R4", "pe_enable emul", {7'b0, pe_enable}, 8'h00);
        check("R4", "dl_allow emul", {7'b0, dl_allow}, 8'h00);
        write_reg(2'd0, 8'h01);
        check("R4", "pe_enable emul off", {7'b0, pe_enable}, 8'h01);
    endtask

    task automatic test_event(input int which, input string req);
        logic [7:0] d;
        do_reset();
        arm();
        @(negedge clk);
        pe_busy = 1'b1;
        #1;
        check(req, "no abort before event", {7'b0, pe_abort}, 8'h00);
        @(negedge clk);
        ev_irq        = (which == 0);
        ev_array_rd   = (which == 1);
        ev_sleep      = (which == 2);
        ev_alt_master = (which == 3);
        #1;
        check(req, "abort same cycle", {7'b0, pe_abort}, 8'h01);
        check(req, "err not yet", {7'b0, err_flag}, 8'h00);
        check(req, "enable held", {7'b0, pe_enable}, 8'h01);
        wait_edge();
        check(req, "err set", {7'b0, err_flag}, 8'h01);
        check(req, "R9 enable dropped", {7'b0, pe_enable}, 8'h00);
        check(req, "R9 dl dropped", {7'b0, dl_allow}, 8'h00);
        @(negedge clk);
        ev_irq = 1'b0; ev_array_rd = 1'b0; ev_sleep = 1'b0; ev_alt_master = 1'b0; pe_busy = 1'b0;
        repeat (3) wait_edge();
        check("R9", "err sticky", {7'b0, err_flag}, 8'h01);
        read_reg(2'd0, d); check("R9", "ctrl err bit", d, 8'h81);
        write_reg(2'd1, 8'hA5);
        check("R9", "enable blocked after rewrite", {7'b0, pe_enable}, 8'h00);
    endtask

    task automatic test_err_write();
        logic [7:0] d;
        do_reset();
        write_reg(2'd0, 8'h80);
        check("R10", "err not set by write", {7'b0, err_flag}, 8'h00);
        read_reg(2'd0, d); check("R10", "ctrl readback", d, 8'h00);
        arm();
        @(negedge clk); pe_busy = 1'b1; ev_sleep = 1'b1;
        wait_edge();
        @(negedge clk); pe_busy = 1'b0; ev_sleep = 1'b0;
        write_reg(2'd0, 8'h00);
        check("R10", "err not cleared by write", {7'b0, err_flag}, 8'h01);
        read_reg(2'd0, d); check("R10", "ctrl err bit", d, 8'h80);
    endtask

    task automatic test_idle();
        do_reset();
        arm();
        @(negedge clk);
        ev_irq = 1'b1; ev_array_rd = 1'b1; ev_sleep = 1'b1; ev_alt_master = 1'b1;
        #1;
        check("R11", "idle abort", {7'b0, pe_abort}, 8'h00);
        repeat (2) wait_edge();
        check("R11", "idle err", {7'b0, err_flag}, 8'h00);
        check("R11", "idle enable", {7'b0, pe_enable}, 8'h01);
        @(negedge clk);
        ev_irq = 1'b0; ev_array_rd = 1'b0; ev_sleep = 1'b0; ev_alt_master = 1'b0;
    endtask

    task automatic test_readback();
        logic [7:0] d;
        do_reset();
        write_reg(2'd0, 8'hFE);
        read_reg(2'd0, d); check("R12", "ctrl", d, 8'h02);
        write_reg(2'd1, 8'h3C);
        read_reg(2'd1, d); check("R12", "key", d, 8'h3C);
        read_reg(2'd2, d); check("R12", "addr2", d, 8'h00);
        write_reg(2'd3, 8'hFF);
        read_reg(2'd3, d); check("R12", "addr3", d, 8'h00);
        read_reg(2'd1, d); check("R12", "key after addr3 write", d, 8'h3C);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        pe_busy = 1'b0; ev_irq = 1'b0; ev_array_rd = 1'b0; ev_sleep = 1'b0; ev_alt_master = 1'b0;
        test_reset();
        test_key();
        test_dl_bit();
        test_emul();
        test_event(0, "R5");
        test_event(1, "R6");
        test_event(2, "R7");
        test_event(3, "R8");
        test_err_write();
        test_idle();
        test_readback();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule